// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides one W-bit integer by another over several clock cycles. It uses a three-register datapath: an accumulator one bit wider than the operands, a quotient register, and a divisor register that also carries an extra sign bit. Each cycle performs one iteration. In that iteration the accumulator and quotient shift left together as one register, and the divisor is added to or subtracted from the accumulator. A mode input, sampled at start, selects the algorithm:

- **Restoring mode** discards a trial difference that comes out negative.
- **Nonrestoring mode** never restores. The sign of the accumulator picks the next operation, and one correction cycle at the end makes the remainder non-negative.

Both modes use the same adder.

A caller presents the operands and pulses `start` while the block is idle. `busy` stays high while the block iterates. `done` pulses for one cycle when the quotient and remainder are valid, and both results hold until the next completion. When the `SIGNED_EN` parameter is set, a per-operation input allows two's-complement operands. The block divides their magnitudes and then fixes the result signs. A zero divisor is caught at start.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: `start` is accepted only while `busy` is 0. `busy` is 1 from the cycle after acceptance until the result is written. `done` is high for exactly one cycle per operation and is never high together with `busy`.
- R3: With `nonrestoring`=0 and unsigned operands, the result is `quotient` = dividend / divisor and `remainder` = dividend mod divisor. `done` is high after the W+2nd rising edge, counting the accepting edge as the first. In this mode the accumulator never holds a negative value between iterations.
- R4: With `nonrestoring`=1, the results are the same as in R3. `done` comes one edge later (W+3), because of the correction cycle. The accumulator is non-negative when the result is written.
- R5: For unsigned operations with a nonzero divisor, `remainder` is less than `divisor`.
- R6: With `SIGNED_EN`=1 and `signed_op`=1, the operands are two's-complement values. The quotient is truncated toward zero and is negated when the operand signs differ. The remainder takes the sign of the dividend. Results wrap to W bits, so the most negative value divided by -1 gives the most negative value.
- R7: A zero divisor sets `div_zero`=1 and gives `quotient` all ones and `remainder` equal to the raw dividend. `done` comes after the accepting edge itself, and `busy` stays 0. The next completion with a nonzero divisor clears `div_zero`.
- R8: A `start` pulse while `busy` is 1 is ignored. The running operation completes with its own result, and no extra `done` occurs.
- R9: `quotient`, `remainder` and `div_zero` change only in a cycle where `done` is 1. Operand inputs that change while the block is idle have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation; accepted when not busy |
| nonrestoring | input | 1 | Algorithm select: 0 restoring, 1 nonrestoring |
| signed_op | input | 1 | Treat operands as two's-complement (effective only with SIGNED_EN) |
| dividend | input | W | Dividend operand |
| divisor | input | W | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; results valid |
| div_zero | output | 1 | Last completed operation had a zero divisor |
| quotient | output | W | Quotient result |
| remainder | output | W | Remainder result |

## Verification
The bench builds the divider with W=8 and SIGNED_EN=1. At this width each operation takes 10 to 11 cycles, so a grid of unsigned operands that spans 0, 1, 127, 128 and 255 can be run in both modes. The signed grid reaches the most negative dividend, -128 divided by -1 with its wrap, and every sign combination. The narrow width also places the sign bit of the accumulator, where restoring and nonrestoring differ, in nearly every iteration. It also lets the bench measure the latency of each mode exactly.

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 8,
  parameter bit SIGNED_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         nonrestoring,
  input  logic         signed_op,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_CORR, S_FIN} state_t;

  state_t        st;
  logic [W:0]    a_r, m_r;
  logic [W-1:0]  q_r;
  logic [CW-1:0] cnt;
  logic          mode_r, sgn_r, negq_r, negr_r;

  logic          sop, dvd_neg, dvs_neg, add_op, q0, last;
  logic [W-1:0]  dvd_mag, dvs_mag, res_q, res_r;
  logic [W:0]    a_sh, add_in, alu, step_a;

  assign busy    = (st != S_IDLE);
  assign sop     = SIGNED_EN && signed_op;
  assign dvd_neg = sop && dividend[W-1];
  assign dvs_neg = sop && divisor[W-1];
  assign dvd_mag = dvd_neg ? -dividend : dividend;
  assign dvs_mag = dvs_neg ? -divisor : divisor;

  assign a_sh   = {a_r[W-1:0], q_r[W-1]};
  assign add_op = (st == S_CORR) || (mode_r && a_r[W]);
  assign add_in = (st == S_CORR) ? a_r : a_sh;
  assign alu    = add_op ? add_in + m_r : add_in - m_r;
  assign step_a = (!mode_r && alu[W]) ? a_sh : alu;
  assign q0     = ~alu[W];
  assign last   = (cnt == CW'(W - 1));

  assign res_q = negq_r ? -q_r : q_r;
  assign res_r = negr_r ? -a_r[W-1:0] : a_r[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      a_r       <= '0;
      m_r       <= '0;
      q_r       <= '0;
      cnt       <= '0;
      mode_r    <= 1'b0;
      sgn_r     <= 1'b0;
      negq_r    <= 1'b0;
      negr_r    <= 1'b0;
      done      <= 1'b0;
      div_zero  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (divisor == '0) begin
              done      <= 1'b1;
              div_zero  <= 1'b1;
              quotient  <= '1;
              remainder <= dividend;
            end else begin
              a_r    <= '0;
              m_r    <= {1'b0, dvs_mag};
              q_r    <= dvd_mag;
              cnt    <= '0;
              mode_r <= nonrestoring;
              sgn_r  <= sop;
              negq_r <= dvd_neg ^ dvs_neg;
              negr_r <= dvd_neg;
              st     <= S_RUN;
            end
          end
        end
        S_RUN: begin
          a_r <= step_a;
          q_r <= {q_r[W-2:0], q0};
          cnt <= cnt + CW'(1);
          if (last) st <= mode_r ? S_CORR : S_FIN;
        end
        S_CORR: begin
          if (a_r[W]) a_r <= alu;
          st <= S_FIN;
        end
        S_FIN: begin
          quotient  <= res_q;
          remainder <= res_r;
          div_zero  <= 1'b0;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_restore_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !mode_r) |-> !a_r[W]);

  p_fix_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN) |-> !a_r[W]);

  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && !sgn_r) |-> (remainder < m_r[W-1:0]));

  p_zero_quot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quotient == '1));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
endmodule

// File: tb/seq_divider_tb_top.sv
`timescale 1ns/1ps
module seq_divider_tb_top;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, nonrest = 1'b0, sop = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, div_zero;
  logic [W-1:0] quotient, remainder;

  always #10 clk = ~clk;

  seq_divider #(.W(W), .SIGNED_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .nonrestoring(nonrest),
    .signed_op(sop), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_zero(div_zero),
    .quotient(quotient), .remainder(remainder));

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         dz;
    int           st;
    int           lat;
    string        tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0, fails = 0, cyc = 0, got_done = 0;
  logic prev_done = 1'b0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      chk(!prev_done, "R2", 1, 0);
      if (sbq.size() == 0) begin
        chk(1'b0, "R8", got_done, -1);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(quotient == e.q, e.tag, quotient, e.q);
        chk(remainder == e.r, e.tag, remainder, e.r);
        chk(div_zero == e.dz, "R7", div_zero, e.dz);
        chk((cyc - e.st) == e.lat, e.tag, cyc - e.st, e.lat);
        if (!e.dz && !sop) chk(remainder < divisor || e.tag == "R8", "R5", remainder, divisor);
      end
      got_done++;
    end
    prev_done = rst_n && done;
  end

  task automatic push_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic md,
                         input logic sg, input string tag);
    exp_t e;
    if (b == '0) begin
      e.q = '1; e.r = a; e.dz = 1'b1; e.lat = 1; e.tag = "R7";
    end else begin
      if (sg) begin
        int sa, sb;
        sa = int'($signed(a)); sb = int'($signed(b));
        e.q = W'(sa / sb); e.r = W'(sa % sb);
      end else begin
        e.q = a / b; e.r = a % b;
      end
      e.dz = 1'b0; e.lat = md ? W + 3 : W + 2; e.tag = tag;
    end
    e.st = cyc;
    sbq.push_back(e);
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic md,
                        input logic sg, input string tag);
    int n;
    @(negedge clk);
    n = got_done;
    dividend = a; divisor = b; nonrest = md; sop = sg; start = 1'b1;
    push_op(a, b, md, sg, tag);
    @(negedge clk);
    start = 1'b0;
    while (got_done == n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ua[8], ub[7], sa[6], sb[6];
    ua = '{0, 1, 7, 100, 127, 128, 200, 255};
    ub = '{1, 2, 3, 13, 127, 128, 255};
    sa = '{-128, -7, -1, 0, 5, 127};
    sb = '{-128, -3, -1, 1, 3, 7};

    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && div_zero == 0, "R1", {busy, done, div_zero}, 0);
    chk(quotient == 0 && remainder == 0, "R1", quotient, 0);
    rst_n = 1'b1;

    for (int md = 0; md < 2; md++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 7; j++)
          run_op(W'(ua[i]), W'(ub[j]), md[0], 1'b0, md ? "R4" : "R3");

    for (int md = 0; md < 2; md++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run_op(W'(sa[i]), W'(sb[j]), md[0], 1'b1, "R6");

    run_op(8'd77, 8'd0, 1'b0, 1'b0, "R7");
    chk(busy == 0, "R7", busy, 0);
    run_op(8'd9, 8'd2, 1'b1, 1'b0, "R4");
    chk(div_zero == 0, "R7", div_zero, 0);
    run_op(8'h85, 8'd0, 1'b1, 1'b1, "R7");

    begin
      int n;
      @(negedge clk);
      n = got_done;
      dividend = 8'd100; divisor = 8'd7; nonrest = 1'b0; sop = 1'b0; start = 1'b1;
      push_op(8'd100, 8'd7, 1'b0, 1'b0, "R8");
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1, "R2", busy, 1);
      repeat (3) @(negedge clk);
      dividend = 8'd50; divisor = 8'd3; nonrest = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      chk(got_done == n + 1, "R8", got_done - n, 1);
      chk(quotient == 8'd14 && remainder == 8'd2, "R8", quotient, 14);
    end

    begin
      logic [W-1:0] hq, hr;
      hq = quotient; hr = remainder;
      dividend = 8'd201; divisor = 8'd0; sop = 1'b1;
      repeat (6) @(negedge clk);
      chk(quotient == hq, "R9", quotient, hq);
      chk(remainder == hr && div_zero == 0, "R9", remainder, hr);
    end

    chk(sbq.size() == 0, "R2", sbq.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule